// File: doc/BRIEF.md
# Saturating Event Counter Bank with Commit

This block holds a bank of event counters that all share one width. Each counter keeps a private working register. When its increment strobe is high, the counter adds its own increment amount to that register. The counter may count how often an event occurs, or how many cycles an event lasts: in the second case the strobe stays high for the length of the event.

Software never sees the working register directly. It sees a separate committed register, which takes a snapshot of the working value only when the counter's submit strobe is high. This lets the agent that produces the events decide when a measurement is complete.

Arithmetic saturates at the all-ones value and never wraps. The counter width is independent of any host bus width and may exceed it. The committed values are driven flat onto one output vector, for a register-read path that lies outside this block.

The event inputs are plain strobes with no ready signal. The bank takes an increment and a submit on every cycle, so it never exerts back-pressure. A producer therefore needs no handshake.

A parameter selects the amount mode. With `AMOUNT_EN` at 1, the per-counter amount input is added. With `AMOUNT_EN` at 0, the step is fixed at 1, which is the default increment of this kind of counter, and the amount input is ignored.

Top module: `evc_bank`

## Requirements
- R1: A high `rst_i` or a high `clr_i` at a clock edge sets every working and every committed register to zero. The cleared committed value appears on `value_o` after that edge.
- R2: At an edge where `inc_i[k]` is high, working register k gains `amount_i[k*CNT_W +: CNT_W]`. Without `submit_i[k]`, slice k of `value_o` does not change.
- R3: At an edge where `submit_i[k]` is high, slice k of `value_o` takes the working value of counter k after that edge's update. This includes an increment presented in the same cycle.
- R4: The working value never exceeds 2^CNT_W−1 and never wraps. A sum beyond that value gives 2^CNT_W−1, even when both the working value and the amount are near the maximum. Further increments leave the value at 2^CNT_W−1.
- R5: A commit does not clear the working register. Later increments continue from the committed total.
- R6: The strobes and the amount of counter k affect only counter k.
- R7: With `AMOUNT_EN`=0, each increment adds exactly 1, and `amount_i` has no effect.
- R8: A clear takes priority over an increment or a submit in the same cycle. The result is zero.
- R9: All `CNT_W` bits count, so carries propagate across bit 32 when `CNT_W` is 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| clr_i | input | 1 | Synchronous clear of all counters, active high |
| inc_i | input | NUM_CNT | Per-counter increment strobe |
| submit_i | input | NUM_CNT | Per-counter commit strobe |
| amount_i | input | NUM_CNT*CNT_W | Per-counter increment amounts, counter k in bits k*CNT_W upward |
| value_o | output | NUM_CNT*CNT_W | Committed values, counter k in bits k*CNT_W upward |

## Verification
The clocked properties depend on the clear inputs being known at every edge. They also assume that `rst_i` is high for at least one edge before counting begins, so that the first `$past` sample is a cleared state. The bench holds reset for several cycles and changes strobes and amounts only on the falling edge. Amounts go up to the all-ones value, so the no-wrap property on the adder meets its worst case, and submits are issued both alone and together with increments and clears.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int unsigned EVC_DEF_NUM = 4;
  localparam int unsigned EVC_DEF_W   = 40;

  typedef enum logic [1:0] {
    EVC_HOLD = 2'd0,
    EVC_ADD  = 2'd1,
    EVC_ZERO = 2'd2
  } evc_op_e;
endpackage

// File: rtl/evc_sat_add.sv
module evc_sat_add #(
  parameter int unsigned W = 40
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam int unsigned EXT_W = W + 1;

  logic [EXT_W-1:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, a_i} + {1'b0, b_i};
    sum_o    = wide_sum[W] ? {W{1'b1}} : wide_sum[W-1:0];
  end

  // R4
  always_comb begin
    sat_nowrap_chk: assert (sum_o >= a_i && sum_o >= b_i);
  end
endmodule

// File: rtl/evc_lane.sv
module evc_lane
  import evc_pkg::*;
#(
  parameter int unsigned CNT_W     = 40,
  parameter bit          AMOUNT_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             submit_i,
  input  logic [CNT_W-1:0] amount_i,
  output logic [CNT_W-1:0] value_o
);
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] work_q;
  logic [CNT_W-1:0] commit_q;
  logic [CNT_W-1:0] added;
  logic [CNT_W-1:0] work_d;
  evc_op_e          op;
  logic             zero_req;

  generate
    if (AMOUNT_EN) begin : g_amount
      assign step = amount_i;
    end else begin : g_unit
      logic unused_amount;
      assign unused_amount = ^amount_i;
      assign step = CNT_W'(1);
    end
  endgenerate

  evc_sat_add #(.W(CNT_W)) adder_i (
    .a_i   (work_q),
    .b_i   (step),
    .sum_o (added)
  );

  assign zero_req = rst_i | clr_i;

  always_comb begin
    if (zero_req)   op = EVC_ZERO;
    else if (inc_i) op = EVC_ADD;
    else            op = EVC_HOLD;
  end

  always_comb begin
    unique case (op)
      EVC_ADD:  work_d = added;
      EVC_ZERO: work_d = '0;
      default:  work_d = work_q;
    endcase
  end

  always_ff @(posedge clk_i) begin
    work_q <= work_d;
    if (zero_req)      commit_q <= '0;
    else if (submit_i) commit_q <= work_d;
  end

  assign value_o = commit_q;

  // R1
  clear_zero_chk: assert property (@(posedge clk_i)
    clr_i |=> (work_q == '0 && commit_q == '0));

  // R2
  hold_commit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!submit_i && !clr_i) |=> $stable(commit_q));

  // R3
  submit_copy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (submit_i && !clr_i) |=> (commit_q == work_q));

  // R4
  monotonic_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !clr_i |=> (work_q >= $past(work_q)));

  // R5
  idle_work_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!inc_i && !clr_i) |=> $stable(work_q));
endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter int unsigned NUM_CNT   = EVC_DEF_NUM,
  parameter int unsigned CNT_W     = EVC_DEF_W,
  parameter bit          AMOUNT_EN = 1'b1
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       clr_i,
  input  logic [NUM_CNT-1:0]         inc_i,
  input  logic [NUM_CNT-1:0]         submit_i,
  input  logic [NUM_CNT*CNT_W-1:0]   amount_i,
  output logic [NUM_CNT*CNT_W-1:0]   value_o
);
  localparam int unsigned FLAT_W = NUM_CNT * CNT_W;

  logic [FLAT_W-1:0] value_flat;

  generate
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_lane
      evc_lane #(
        .CNT_W     (CNT_W),
        .AMOUNT_EN (AMOUNT_EN)
      ) lane_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .clr_i    (clr_i),
        .inc_i    (inc_i[k]),
        .submit_i (submit_i[k]),
        .amount_i (amount_i[k*CNT_W +: CNT_W]),
        .value_o  (value_flat[k*CNT_W +: CNT_W])
      );
    end
  endgenerate

  assign value_o = value_flat;
endmodule

// File: tb/evc_bank_tb.sv
module evc_bank_tb_top;
  localparam int unsigned N = 4;
  localparam int unsigned W = 40;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic [N-1:0]   inc = '0;
  logic [N-1:0]   sub = '0;
  logic [N*W-1:0] amt = '0;
  logic [N*W-1:0] val;
  logic [N*W-1:0] uval;

  int vectors = 0;
  int errors  = 0;
  logic [W-1:0] mw [N];
  logic [W-1:0] mc [N];
  logic [W-1:0] uw [N];
  logic [W-1:0] uc [N];

  always #4 clk = ~clk;

  evc_bank #(.NUM_CNT(N), .CNT_W(W), .AMOUNT_EN(1'b1)) dut_i (
    .clk_i(clk), .rst_i(rst), .clr_i(clr), .inc_i(inc),
    .submit_i(sub), .amount_i(amt), .value_o(val));

  evc_bank #(.NUM_CNT(N), .CNT_W(W), .AMOUNT_EN(1'b0)) dut_unit_i (
    .clk_i(clk), .rst_i(rst), .clr_i(clr), .inc_i(inc),
    .submit_i(sub), .amount_i(amt), .value_o(uval));

  function automatic logic [W-1:0] sat(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W] ? MAXV : s[W-1:0];
  endfunction

  task automatic tick();
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      logic [W-1:0] nw, nu;
      if (rst || clr) begin
        mw[i] = '0; mc[i] = '0; uw[i] = '0; uc[i] = '0;
      end else begin
        nw = inc[i] ? sat(mw[i], amt[i*W +: W]) : mw[i];
        nu = inc[i] ? sat(uw[i], W'(1)) : uw[i];
        if (sub[i]) begin mc[i] = nw; uc[i] = nu; end
        mw[i] = nw; uw[i] = nu;
      end
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic [N-1:0] i_v, input logic [N-1:0] s_v,
                       input logic [N*W-1:0] a_v, input logic c_v);
    inc = i_v; sub = s_v; amt = a_v; clr = c_v;
    tick();
    inc = '0; sub = '0; clr = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int i = 0; i < N; i++) begin
      chk(tag, val[i*W +: W], mc[i]);
      chk({tag, " R7 unit"}, uval[i*W +: W], uc[i]);
    end
  endtask

  function automatic logic [N*W-1:0] one_amt(input int k, input logic [W-1:0] v);
    logic [N*W-1:0] r;
    r = '0;
    r[k*W +: W] = v;
    return r;
  endfunction

  task automatic t_reset();
    chk_all("R1 reset");
    for (int i = 0; i < N; i++) chk("R1 reset zero", val[i*W +: W], '0);
  endtask

  task automatic t_basic();
    for (int j = 0; j < 4; j++) begin
      drive(4'b0001, 4'b0000, one_amt(0, 40'd3), 1'b0);
      chk_all("R2 no submit");
    end
    chk("R2 held at zero", val[0 +: W], '0);
    drive(4'b0000, 4'b0001, '0, 1'b0);
    chk_all("R3 submit");
    chk("R3 committed 12", val[0 +: W], 40'd12);
    chk("R7 unit count 4", uval[0 +: W], 40'd4);
  endtask

  task automatic t_same_cycle();
    drive(4'b0001, 4'b0001, one_amt(0, 40'd5), 1'b0);
    chk("R3 same-cycle inc", val[0 +: W], 40'd17);
    chk_all("R3 same-cycle");
  endtask

  task automatic t_keep();
    drive(4'b0001, 4'b0000, one_amt(0, 40'd2), 1'b0);
    chk("R5 commit held", val[0 +: W], 40'd17);
    drive(4'b0000, 4'b0001, '0, 1'b0);
    chk("R5 continues from total", val[0 +: W], 40'd19);
    chk_all("R5 keep");
  endtask

  task automatic t_wide();
    drive(4'b0010, 4'b0000, one_amt(1, 40'hFFFF_FFFF), 1'b0);
    drive(4'b0010, 4'b0010, one_amt(1, 40'hFFFF_FFFF), 1'b0);
    chk("R9 carry past bit 32", val[W +: W], 40'h1_FFFF_FFFE);
    chk_all("R9 wide");
  endtask

  task automatic t_sat();
    drive(4'b0100, 4'b0000, one_amt(2, MAXV - 40'd1), 1'b0);
    drive(4'b0100, 4'b0100, one_amt(2, MAXV), 1'b0);
    chk("R4 saturate no wrap", val[2*W +: W], MAXV);
    drive(4'b0100, 4'b0100, one_amt(2, 40'd1), 1'b0);
    chk("R4 stays at max", val[2*W +: W], MAXV);
    chk_all("R4 sat");
  endtask

  task automatic t_indep();
    logic [N*W-1:0] a;
    a = '0;
    for (int i = 0; i < N; i++) a[i*W +: W] = W'(i + 7);
    drive(4'b1111, 4'b1000, a, 1'b0);
    chk("R6 counter3 committed", val[3*W +: W], 40'd10);
    chk("R6 counter0 unchanged", val[0 +: W], 40'd19);
    chk("R6 counter1 unchanged", val[W +: W], 40'h1_FFFF_FFFE);
    chk_all("R6 indep");
    drive(4'b0000, 4'b0011, '0, 1'b0);
    chk("R6 counter0 own amount", val[0 +: W], 40'd26);
    chk_all("R6 indep2");
  endtask

  task automatic t_clr_prio();
    drive(4'b1111, 4'b1111, {N{40'd9}}, 1'b1);
    chk_all("R8 clear priority");
    for (int i = 0; i < N; i++) chk("R8 zero after clear", val[i*W +: W], '0);
    drive(4'b0000, 4'b1111, '0, 1'b0);
    chk("R1 working cleared", val[W +: W], '0);
    chk_all("R1 after clear");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mw[i] = '0; mc[i] = '0; uw[i] = '0; uc[i] = '0; end
    @(negedge clk);
    rst = 1'b1;
    repeat (4) tick();
    rst = 1'b0;
    t_reset();
    t_basic();
    t_same_cycle();
    t_keep();
    t_wide();
    t_sat();
    t_indep();
    t_clr_prio();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule